// File: doc/BRIEF.md
# Skip and Jump Condition Evaluator

This block sits in the execute stage of a 36-bit processor and decides what happens to the program counter after an instruction's arithmetic is complete. From the 18-bit instruction halfword (opcode in the top nine bits), the 36-bit result of the adder or mask stage, the two adder carries and the four processor status flags, it decides whether the counter is loaded with the jump target (`pc_set`) or advanced by one more word to skip the next instruction (`pc_inc`). It also raises a one-cycle strobe telling the flag logic that the program counter was changed.

Compare and test classes share a three-bit condition field taken from the low opcode bits: a less-than term, a zero term and a sense inversion. The less-than term uses the result sign corrected for arithmetic overflow. Whether a true condition produces a jump or a skip depends on the class. The evaluation is combinational and the three outputs are registered on the execute strobe. They are single-cycle pulses in the cycle after the strobe. The program counter register lives elsewhere.

Top module: `skip_jump_eval`

## Requirements
- R1: While `rst_n` is low at a clock edge, all three outputs are 0 on the following cycle, whatever the other inputs are.
- R2: The less-than term is `result[35]` XOR (`cry0` XOR `cry1`). A negative result with equal carries counts as less than zero. So does a positive result with unequal carries, which marks overflow.
- R3: The condition is ((opcode bit 0 set and less-than holds) or (opcode bit 1 set and `result` is zero)), inverted when opcode bit 2 is set. Opcode bit 0 is instruction bit 9.
- R4: Opcodes octal 300 to 317 assert `pc_inc` exactly when the R3 condition holds and never assert `pc_set`.
- R5: Opcodes octal 320 to 377 evaluate the R3 condition. When opcode bit 3 is clear (AC destination), a true condition asserts `pc_set`. When opcode bit 3 is set (memory destination), it asserts `pc_inc`.
- R6: Opcode octal 253 asserts `pc_set` when `result[35]` is 1. Opcode octal 252 asserts `pc_set` when `result[35]` is 0.
- R7: Opcode octal 255 asserts `pc_set` when any flag selected by instruction bits 8:5 is set. Bit 8 selects `flags[3]` (overflow), bit 7 selects `flags[2]` (carry 0), bit 6 selects `flags[1]` (carry 1) and bit 5 selects `flags[0]` (PC changed).
- R8: In opcodes octal 700 to 777, function field instruction bits 7:5 = 6 asserts `pc_inc` when `result` (the masked status) is zero, and function 7 asserts it when `result` is nonzero. Other function values do neither.
- R9: Opcode octal 254 and opcodes octal 260 to 267 assert `pc_set` unconditionally, except 261 and 262, which assert neither output.
- R10: Opcodes octal 600 to 677 assert `pc_inc` per R3 with the less-than term disabled. Opcode bit 0 has no effect, and these opcodes never assert `pc_set`.
- R11: `pc_chg_stb` is 1 whenever `pc_set` or `pc_inc` is 1. The one exception is opcode octal 254 with instruction bit 6 set, where it stays 0.
- R12: Results appear in the cycle after a clock edge where `exec_stb` is 1 and last one cycle. After an edge where `exec_stb` is 0, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exec_stb | input | 1 | Execute-phase strobe; registers a decision |
| instr | input | 18 | Instruction halfword, opcode in bits 17:9 |
| result | input | 36 | Adder result or masked device status |
| cry0 | input | 1 | Carry out of the sign position |
| cry1 | input | 1 | Carry into the sign position |
| flags | input | 4 | Status flags: [3] overflow, [2] carry 0, [1] carry 1, [0] PC changed |
| pc_set | output | 1 | Load the program counter with the jump target |
| pc_inc | output | 1 | Advance the program counter to skip one instruction |
| pc_chg_stb | output | 1 | Strobe to raise the PC-changed flag |

## Verification
The bench goes after the less-than term at the overflow boundary. A positive result with mismatched carries must count as negative, and a design that used the raw sign would skip on the wrong side of zero. It drives the same condition field through the compare, modify and test classes. A design that let the less-than bit leak into the test class, or swapped jump and skip by destination, would move the wrong output. It covers the unconditional jump group edges: push and pop must stay quiet, and the restore-flags variant must jump without the change strobe. It also checks both polarities of the device skip and the flag-select jump, where a wrong bit mapping selects the wrong flag.

// File: rtl/skj_pkg.sv
// Shared types for the skip/jump evaluator.
// Assumes an 18-bit instruction halfword with a 9-bit opcode on top.
package skj_pkg;

    localparam int OP_W = 9;

    // Decision class of the current instruction
    typedef enum logic [3:0] {
        CL_NONE,
        CL_CMP_SKIP,      // compare, skip on condition
        CL_MOD_JUMP,      // modify-and-test, AC destination
        CL_MOD_SKIP,      // modify-and-test, memory destination
        CL_IDX_NONNEG,    // index loop, jump while sign clear
        CL_IDX_NEG,       // index loop, jump while sign set
        CL_FLAG_JUMP,     // jump on selected status flags
        CL_RESTORE_JUMP,  // unconditional jump, may restore flags
        CL_JUMP,          // unconditional jump group
        CL_TEST_SKIP,     // bit test, zero term only
        CL_DEV_ZERO,      // device skip if masked status zero
        CL_DEV_ANY        // device skip if any masked bit set
    } sj_class_e;

endpackage

// File: rtl/skj_class_decode.sv
// Maps the instruction halfword onto a decision class.
// Groups are compared on the upper six opcode bits; device
// skips also look at the function field below the opcode.
module skj_class_decode
    import skj_pkg::*;
#(
    parameter int HALF_W = 18
) (
    input  logic [HALF_W-1:0] instr,
    output sj_class_e         cls
);
    localparam int OP_LSB = HALF_W - OP_W;

    logic [OP_W-1:0] op;
    logic [5:0]      grp;
    logic [2:0]      low;
    logic [2:0]      dev_fn;

    assign op     = instr[HALF_W-1:OP_LSB];
    assign grp    = op[OP_W-1:3];
    assign low    = op[2:0];
    assign dev_fn = instr[7:5];

    // Class selection by opcode group
    always_comb begin
        cls = CL_NONE;
        if (grp == 6'o30 || grp == 6'o31) begin
            cls = CL_CMP_SKIP;
        end else if (grp[5:3] == 3'o3) begin
            cls = grp[0] ? CL_MOD_SKIP : CL_MOD_JUMP;
        end else if (grp == 6'o25) begin
            case (low)
                3'd2:    cls = CL_IDX_NONNEG;
                3'd3:    cls = CL_IDX_NEG;
                3'd4:    cls = CL_RESTORE_JUMP;
                3'd5:    cls = CL_FLAG_JUMP;
                default: cls = CL_NONE;
            endcase
        end else if (grp == 6'o26) begin
            cls = (low == 3'd1 || low == 3'd2) ? CL_NONE : CL_JUMP;
        end else if (grp[5:3] == 3'o6) begin
            cls = CL_TEST_SKIP;
        end else if (grp[5:3] == 3'o7) begin
            if (dev_fn == 3'd6)      cls = CL_DEV_ZERO;
            else if (dev_fn == 3'd7) cls = CL_DEV_ANY;
        end
    end

endmodule

// File: rtl/skj_cond_eval.sv
// Evaluates the three-bit condition field against the result.
// Assumes the carries describe the same addition as the result.
module skj_cond_eval #(
    parameter int WORD_W = 36
) (
    input  logic [WORD_W-1:0] result,
    input  logic              cry0,
    input  logic              cry1,
    input  logic [2:0]        field,   // [0] less, [1] zero, [2] sense
    input  logic              lt_en,
    output logic              hit,
    output logic              is_zero
);
    logic less;

    // Sign corrected for overflow, zero detect, final condition
    always_comb begin
        less    = result[WORD_W-1] ^ (cry0 ^ cry1);
        is_zero = (result == '0);
        hit     = ((field[0] & lt_en & less) | (field[1] & is_zero)) ^ field[2];
    end

endmodule

// File: rtl/skj_flag_select.sv
// Reports whether any status flag picked by a select mask is set.
// Select and flag vectors share the same bit order.
module skj_flag_select #(
    parameter int N_FLAG = 4
) (
    input  logic [N_FLAG-1:0] sel,
    input  logic [N_FLAG-1:0] flags,
    output logic              any_hit
);
    logic [N_FLAG-1:0] masked;

    // Per-flag gating, one lane per flag
    for (genvar i = 0; i < N_FLAG; i++) begin : g_lane
        assign masked[i] = sel[i] & flags[i];
    end

    assign any_hit = |masked;

endmodule

// File: rtl/skip_jump_eval.sv
// Top of the skip/jump evaluator. Combines the class decode,
// condition and flag select, then registers pc_set, pc_inc and
// the PC-changed strobe as one-cycle pulses after exec_stb.
module skip_jump_eval
    import skj_pkg::*;
#(
    parameter int WORD_W = 36,
    parameter int HALF_W = 18,
    parameter int N_FLAG = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec_stb,
    input  logic [HALF_W-1:0] instr,
    input  logic [WORD_W-1:0] result,
    input  logic              cry0,
    input  logic              cry1,
    input  logic [N_FLAG-1:0] flags,
    output logic              pc_set,
    output logic              pc_inc,
    output logic              pc_chg_stb
);
    localparam int OP_LSB      = HALF_W - OP_W;
    localparam int FSEL_LSB    = 5;
    localparam int RESTORE_BIT = 6;

    sj_class_e cls;
    logic      lt_en;
    logic      cond_hit;
    logic      res_zero;
    logic      flag_hit;
    logic      set_nx;
    logic      inc_nx;
    logic      chg_nx;

    skj_class_decode #(.HALF_W(HALF_W)) u_decode (
        .instr (instr),
        .cls   (cls)
    );

    skj_cond_eval #(.WORD_W(WORD_W)) u_cond (
        .result  (result),
        .cry0    (cry0),
        .cry1    (cry1),
        .field   (instr[OP_LSB+2:OP_LSB]),
        .lt_en   (lt_en),
        .hit     (cond_hit),
        .is_zero (res_zero)
    );

    skj_flag_select #(.N_FLAG(N_FLAG)) u_flags (
        .sel     (instr[FSEL_LSB+N_FLAG-1:FSEL_LSB]),
        .flags   (flags),
        .any_hit (flag_hit)
    );

    // Less-than term is only meaningful for compare and modify classes
    assign lt_en = (cls == CL_CMP_SKIP) || (cls == CL_MOD_JUMP) || (cls == CL_MOD_SKIP);

    // Per-class jump/skip decision
    always_comb begin
        set_nx = 1'b0;
        inc_nx = 1'b0;
        case (cls)
            CL_CMP_SKIP:     inc_nx = cond_hit;
            CL_MOD_JUMP:     set_nx = cond_hit;
            CL_MOD_SKIP:     inc_nx = cond_hit;
            CL_IDX_NONNEG:   set_nx = ~result[WORD_W-1];
            CL_IDX_NEG:      set_nx = result[WORD_W-1];
            CL_FLAG_JUMP:    set_nx = flag_hit;
            CL_RESTORE_JUMP: set_nx = 1'b1;
            CL_JUMP:         set_nx = 1'b1;
            CL_TEST_SKIP:    inc_nx = cond_hit;
            CL_DEV_ZERO:     inc_nx = res_zero;
            CL_DEV_ANY:      inc_nx = ~res_zero;
            default:         ;
        endcase
        chg_nx = (set_nx | inc_nx) &
                 ~((cls == CL_RESTORE_JUMP) & instr[RESTORE_BIT]);
    end

    // Output pulse register, loaded only on the execute strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_set     <= 1'b0;
            pc_inc     <= 1'b0;
            pc_chg_stb <= 1'b0;
        end else begin
            pc_set     <= exec_stb & set_nx;
            pc_inc     <= exec_stb & inc_nx;
            pc_chg_stb <= exec_stb & chg_nx;
        end
    end

endmodule

// File: rtl/skj_checker.sv
// Protocol checks for skip_jump_eval, attached by bind.
module skj_checker #(
    parameter int WORD_W = 36,
    parameter int HALF_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              exec_stb,
    input logic [HALF_W-1:0] instr,
    input logic [WORD_W-1:0] result,
    input logic              pc_set,
    input logic              pc_inc,
    input logic              pc_chg_stb
);
    localparam int OP_LSB = HALF_W - 9;

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_stb |=> (!pc_set && !pc_inc && !pc_chg_stb));

    a_r11_chg_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        pc_chg_stb |-> (pc_set || pc_inc));

    a_r9_push_pop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_stb && (instr[HALF_W-1:OP_LSB] == 9'o261 || instr[HALF_W-1:OP_LSB] == 9'o262))
        |=> (!pc_set && !pc_inc));

    a_r10_test_no_jump: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_stb && instr[HALF_W-1:HALF_W-3] == 3'b110) |=> !pc_set);

    a_r4_sense_only_skips: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_stb && instr[HALF_W-1:OP_LSB] == 9'o304) |=> (pc_inc && !pc_set));

    a_r6_neg_loop: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_stb && instr[HALF_W-1:OP_LSB] == 9'o253) |=> (pc_set == $past(result[WORD_W-1])));

endmodule

bind skip_jump_eval skj_checker #(.WORD_W(WORD_W), .HALF_W(HALF_W)) u_skj_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .exec_stb   (exec_stb),
    .instr      (instr),
    .result     (result),
    .pc_set     (pc_set),
    .pc_inc     (pc_inc),
    .pc_chg_stb (pc_chg_stb)
);

// File: tb/tb_skip_jump_eval.sv
// Scoreboard bench: the driver queues expected decisions, the
// monitor compares them one cycle after each execute strobe.
module tb_skip_jump_eval;

    typedef struct {
        logic [2:0] v;     // {set, inc, chg}
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exec_stb = 1'b0;
    logic [17:0] instr = '0;
    logic [35:0] result = '0;
    logic        cry0 = 1'b0;
    logic        cry1 = 1'b0;
    logic [3:0]  flags = '0;
    logic        pc_set, pc_inc, pc_chg_stb;

    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #10 clk = ~clk;

    skip_jump_eval dut (
        .clk(clk), .rst_n(rst_n), .exec_stb(exec_stb), .instr(instr),
        .result(result), .cry0(cry0), .cry1(cry1), .flags(flags),
        .pc_set(pc_set), .pc_inc(pc_inc), .pc_chg_stb(pc_chg_stb)
    );

    // Reference decision written from the requirements
    function automatic logic [2:0] model(input logic [17:0] ins, input logic [35:0] res,
                                         input logic c0, input logic c1, input logic [3:0] fl);
        logic [8:0] op;
        logic lt, z, cmp, tst, s, i, c;
        op  = ins[17:9];
        lt  = res[35] ^ (c0 ^ c1);
        z   = (res == 36'd0);
        cmp = ((op[0] & lt) | (op[1] & z)) ^ op[2];
        tst = (op[1] & z) ^ op[2];
        s = 1'b0; i = 1'b0;
        if (op >= 9'o300 && op <= 9'o317) i = cmp;
        else if (op >= 9'o320 && op <= 9'o377) begin
            if (op[3]) i = cmp; else s = cmp;
        end
        else if (op == 9'o252) s = ~res[35];
        else if (op == 9'o253) s = res[35];
        else if (op == 9'o254) s = 1'b1;
        else if (op == 9'o255) s = |(ins[8:5] & fl);
        else if (op >= 9'o260 && op <= 9'o267) s = (op != 9'o261) && (op != 9'o262);
        else if (op >= 9'o600 && op <= 9'o677) i = tst;
        else if (op >= 9'o700) begin
            if (ins[7:5] == 3'd6) i = z;
            else if (ins[7:5] == 3'd7) i = ~z;
        end
        c = (s | i) & ~(op == 9'o254 && ins[6]);
        return {s, i, c};
    endfunction

    // Driver: one execute strobe with its expected result queued
    task automatic apply(input logic [17:0] ins, input logic [35:0] res,
                         input logic c0, input logic c1, input logic [3:0] fl, input string tag);
        exp_t e;
        @(negedge clk);
        instr = ins; result = res; cry0 = c0; cry1 = c1; flags = fl;
        exec_stb = 1'b1;
        @(posedge clk);
        e.v = model(ins, res, c0, c1, fl);
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        exec_stb = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compares outputs a little after every clock edge
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            exp_t e;
            if (sb.size() > 0) e = sb.pop_front();
            else begin e.v = 3'b000; e.tag = "R12 idle"; end
            total++;
            if ({pc_set, pc_inc, pc_chg_stb} !== e.v) begin
                bad++;
                $display("FAIL %s: got set/inc/chg=%b expected=%b",
                         e.tag, {pc_set, pc_inc, pc_chg_stb}, e.v);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            bad++; total++;
            $display("FAIL watchdog: got running expected finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    localparam logic [35:0] NEG  = 36'o400000000005;
    localparam logic [35:0] POS  = 36'o000000000007;
    localparam logic [35:0] ZERO = 36'o0;

    initial begin
        // R1: reset dominates a live strobe
        instr = {9'o254, 9'o0};
        exec_stb = 1'b1;
        repeat (3) @(negedge clk);
        total++;
        if ({pc_set, pc_inc, pc_chg_stb} !== 3'b000) begin
            bad++;
            $display("FAIL R1 reset: got %b expected 000", {pc_set, pc_inc, pc_chg_stb});
        end
        exec_stb = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R4 / R3 compare class
        apply({9'o300, 9'o0}, ZERO, 0, 0, 4'h0, "R4 never");
        apply({9'o304, 9'o0}, POS,  0, 0, 4'h0, "R4 always");
        apply({9'o302, 9'o0}, ZERO, 0, 0, 4'h0, "R3 zero hit");
        apply({9'o302, 9'o0}, POS,  0, 0, 4'h0, "R3 zero miss");
        apply({9'o306, 9'o0}, ZERO, 0, 0, 4'h0, "R3 sense not-zero");
        apply({9'o303, 9'o0}, ZERO, 0, 0, 4'h0, "R3 less-or-equal");
        // R2 overflow-corrected sign
        apply({9'o301, 9'o0}, NEG,  0, 0, 4'h0, "R2 negative");
        apply({9'o301, 9'o0}, POS,  1, 0, 4'h0, "R2 positive with overflow");
        apply({9'o301, 9'o0}, NEG,  0, 1, 4'h0, "R2 negative with overflow");
        apply({9'o305, 9'o0}, POS,  0, 0, 4'h0, "R2 not-less");
        // R5 modify classes
        apply({9'o322, 9'o0}, ZERO, 0, 0, 4'h0, "R5 AC jump");
        apply({9'o332, 9'o0}, ZERO, 0, 0, 4'h0, "R5 mem skip");
        apply({9'o341, 9'o0}, NEG,  0, 0, 4'h0, "R5 AC less jump");
        apply({9'o371, 9'o0}, NEG,  0, 0, 4'h0, "R5 mem less skip");
        apply({9'o366, 9'o0}, ZERO, 0, 0, 4'h0, "R5 AC no jump");
        // R6 index loops
        apply({9'o252, 9'o0}, POS,  0, 0, 4'h0, "R6 nonneg jumps");
        apply({9'o252, 9'o0}, NEG,  0, 0, 4'h0, "R6 nonneg falls");
        apply({9'o253, 9'o0}, NEG,  0, 0, 4'h0, "R6 neg jumps");
        apply({9'o253, 9'o0}, POS,  0, 0, 4'h0, "R6 neg falls");
        // R7 flag jump
        apply({9'o255, 4'b1000, 5'd0}, ZERO, 0, 0, 4'b1000, "R7 overflow selected");
        apply({9'o255, 4'b0010, 5'd0}, ZERO, 0, 0, 4'b1101, "R7 carry1 clear");
        apply({9'o255, 4'b0001, 5'd0}, ZERO, 0, 0, 4'b0001, "R7 pc-changed selected");
        // R9 / R11 jump group
        apply({9'o254, 9'o000}, ZERO, 0, 0, 4'h0, "R9 R11 plain jump");
        apply({9'o254, 9'o100}, ZERO, 0, 0, 4'h0, "R11 restore no strobe");
        apply({9'o260, 9'o0}, POS,  0, 0, 4'h0, "R9 call");
        apply({9'o261, 9'o0}, POS,  0, 0, 4'h0, "R9 push quiet");
        apply({9'o262, 9'o0}, POS,  0, 0, 4'h0, "R9 pop quiet");
        apply({9'o265, 9'o0}, POS,  0, 0, 4'h0, "R9 link jump");
        // R10 test class
        apply({9'o602, 9'o0}, ZERO, 0, 0, 4'h0, "R10 zero skip");
        apply({9'o603, 9'o0}, NEG,  0, 0, 4'h0, "R10 less bit ignored");
        apply({9'o606, 9'o0}, POS,  0, 0, 4'h0, "R10 nonzero skip");
        // R8 device skips
        apply(18'o700300, ZERO, 0, 0, 4'h0, "R8 zero skip hit");
        apply(18'o700300, POS,  0, 0, 4'h0, "R8 zero skip miss");
        apply(18'o700340, POS,  0, 0, 4'h0, "R8 any skip hit");
        apply(18'o700340, ZERO, 0, 0, 4'h0, "R8 any skip miss");
        apply(18'o700200, ZERO, 0, 0, 4'h0, "R8 other function");
        apply({9'o200, 9'o0}, ZERO, 0, 0, 4'h0, "R12 unrelated opcode");
        // R12 strobe gating
        idle(2);
        @(negedge clk);
        instr = {9'o254, 9'o0};
        repeat (3) @(negedge clk);
        apply({9'o304, 9'o0}, ZERO, 0, 0, 4'h0, "R12 single pulse");
        idle(3);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule